// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Flush

This block keeps a small set of recently used page-table entries so that most address translations avoid a page-table access. Every stored entry holds a virtual page number as its tag, the physical page number it maps to, a valid flag and a dirty flag. A lookup presents a virtual page number. In the same cycle, the block compares it against every valid tag, then reports hit or miss, the physical page number and the stored dirty flag. A lookup that is marked as a write and hits sets that entry's dirty flag at the next clock edge.

After a miss, the page-table walker outside this block installs the entry it fetched through the fill port. A fill goes to the lowest-numbered invalid slot. When no slot is free, it goes to the slot named by a round-robin pointer. A fill whose virtual page number is already stored rewrites that slot, so no duplicate is ever created. When the running process changes, a flush invalidates every entry in one cycle, so translations from one process can never be used by the next.

Each cycle is decoded into one named operation. OP_IDLE does nothing. OP_FLUSH clears every entry. OP_FILL installs an entry. OP_MARK sets the dirty flag of the hit entry. OP_FILL_MARK does both a fill and a mark. The decode takes these transitions in order. A flush request always gives OP_FLUSH. Otherwise, a fill with a write hit gives OP_FILL_MARK. Otherwise, a fill alone gives OP_FILL. Otherwise, a write hit alone gives OP_MARK. Anything else gives OP_IDLE. The contents are updated at the end of the cycle according to the operation.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss.
- R2: A lookup with `lk_valid_i` high hits in the same cycle exactly when a valid entry holds `lk_vpn_i`. On a hit, `lk_ppn_o` and `lk_dirty_o` show that entry's stored values. `lk_hit_o` is low whenever `lk_valid_i` is low, and it shows the contents as they were before any fill or mark in the same cycle.
- R3: A lookup with `lk_write_i` high that hits sets that entry's dirty flag at the next edge. In the hit cycle, `lk_dirty_o` shows the value from before the write.
- R4: A fill of a virtual page number that is not stored goes to the lowest-numbered invalid slot, and its physical page number and dirty flag are taken from the fill port.
- R5: When all slots are valid, a fill of a new virtual page number replaces the slot named by the round-robin pointer, and the pointer then steps by one, wrapping from ENTRIES-1 to 0. The pointer is 0 after reset, and no other operation changes it.
- R6: A fill of a virtual page number that is already stored rewrites that slot's physical page number and dirty flag, evicts no other entry and leaves the pointer unchanged. If a fill and a write-hit mark target the same slot in one cycle, the fill data wins.
- R7: A flush invalidates every entry at the next edge. A lookup in the flush cycle reports a miss, and a fill or write in that cycle has no effect.
- R8: No two valid entries ever hold the same virtual page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries (process switch) |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Virtual page number to translate |
| lk_write_i | input | 1 | Lookup is a write access; mark dirty on hit |
| lk_hit_o | output | 1 | Lookup hit |
| lk_ppn_o | output | PPN_W | Physical page number of the hit entry, 0 on miss |
| lk_dirty_o | output | 1 | Stored dirty flag of the hit entry, 0 on miss |
| fill_valid_i | input | 1 | Install an entry |
| fill_vpn_i | input | VPN_W | Virtual page number of the entry to install |
| fill_ppn_i | input | PPN_W | Physical page number of the entry to install |
| fill_dirty_i | input | 1 | Dirty flag of the entry to install |

## Verification
The assertions assume that the walker fills only through the fill port. Under that assumption, the uniqueness check relies on the fill path finding an existing tag before it picks a free or round-robin slot. They also assume that inputs are stable around the rising edge. The bench drives every input on the falling edge and samples results just after, which meets that assumption. The random stimulus draws page numbers from a range only slightly larger than the slot count. This makes hits, duplicate fills, evictions and write marks frequent, and it mixes in rare flushes, some of which coincide with fills and writes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_FLUSH,
        OP_FILL,
        OP_MARK,
        OP_FILL_MARK
    } tlb_op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 19,
    parameter int IDX_W   = 6
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic [ENTRIES-1:0]              valid_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0]   tags_i,
    input  logic [VPN_W-1:0]                key_i,
    output logic [ENTRIES-1:0]              match_o,
    output logic                            hit_o,
    output logic [IDX_W-1:0]                idx_o
);
    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_o[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    assign hit_o = |match_o;

    // R8
    single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(match_o));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               advance_i,
    output logic               free_found_o,
    output logic [IDX_W-1:0]   free_idx_o,
    output logic [IDX_W-1:0]   rr_idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;

    always_comb begin
        free_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_idx_o = IDX_W'(i);
        end
    end

    assign free_found_o = ~&valid_i;
    assign rr_idx_o     = rr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rr_q <= '0;
        end else if (advance_i) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    // R5
    rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !advance_i |=> $stable(rr_q));

    // R5
    rr_full_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        advance_i |-> (valid_i == '1));
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 19,
    parameter int PPN_W   = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             flush_i,
    input  logic             lk_valid_i,
    input  logic [VPN_W-1:0] lk_vpn_i,
    input  logic             lk_write_i,
    output logic             lk_hit_o,
    output logic [PPN_W-1:0] lk_ppn_o,
    output logic             lk_dirty_o,
    input  logic             fill_valid_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PPN_W-1:0] fill_ppn_i,
    input  logic             fill_dirty_i
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]            valid_q, dirty_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;

    logic [ENTRIES-1:0] lk_match, fill_match;
    logic               lk_any, fill_any, free_any, rr_use, mark;
    logic [IDX_W-1:0]   lk_idx, fill_midx, free_idx, rr_idx, fill_idx;
    tlb_op_e            op_d;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
        .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_q), .tags_i(vpn_q),
        .key_i(lk_vpn_i), .match_o(lk_match), .hit_o(lk_any), .idx_o(lk_idx)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_fill_match (
        .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_q), .tags_i(vpn_q),
        .key_i(fill_vpn_i), .match_o(fill_match), .hit_o(fill_any), .idx_o(fill_midx)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_q), .advance_i(rr_use),
        .free_found_o(free_any), .free_idx_o(free_idx), .rr_idx_o(rr_idx)
    );

    // Lookup outputs
    always_comb begin
        lk_hit_o   = lk_valid_i && !flush_i && lk_any;
        lk_ppn_o   = lk_hit_o ? ppn_q[lk_idx] : '0;
        lk_dirty_o = lk_hit_o ? dirty_q[lk_idx] : 1'b0;
        mark       = lk_hit_o && lk_write_i;
    end

    // Operation decode
    always_comb begin
        if (flush_i)                   op_d = OP_FLUSH;
        else if (fill_valid_i && mark) op_d = OP_FILL_MARK;
        else if (fill_valid_i)         op_d = OP_FILL;
        else if (mark)                 op_d = OP_MARK;
        else                           op_d = OP_IDLE;
    end

    always_comb begin
        fill_idx = fill_any ? fill_midx : (free_any ? free_idx : rr_idx);
        rr_use   = (op_d == OP_FILL || op_d == OP_FILL_MARK) && !fill_any && !free_any;
    end

    // Storage update
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valid_q <= '0;
            dirty_q <= '0;
            vpn_q   <= '0;
            ppn_q   <= '0;
        end else begin
            unique case (op_d)
                OP_IDLE: ;
                OP_FLUSH: begin
                    valid_q <= '0;
                end
                OP_MARK: begin
                    dirty_q[lk_idx] <= 1'b1;
                end
                OP_FILL: begin
                    valid_q[fill_idx] <= 1'b1;
                    vpn_q[fill_idx]   <= fill_vpn_i;
                    ppn_q[fill_idx]   <= fill_ppn_i;
                    dirty_q[fill_idx] <= fill_dirty_i;
                end
                OP_FILL_MARK: begin
                    dirty_q[lk_idx]   <= 1'b1;
                    valid_q[fill_idx] <= 1'b1;
                    vpn_q[fill_idx]   <= fill_vpn_i;
                    ppn_q[fill_idx]   <= fill_ppn_i;
                    dirty_q[fill_idx] <= fill_dirty_i;
                end
                default: ;
            endcase
        end
    end

    // R7
    flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (valid_q == '0));

    // R3
    mark_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_d == OP_MARK) |=> dirty_q[$past(lk_idx)]);

    // R4
    fill_install_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_valid_i && !flush_i) |=> (valid_q[$past(fill_idx)]
            && vpn_q[$past(fill_idx)] == $past(fill_vpn_i)
            && ppn_q[$past(fill_idx)] == $past(fill_ppn_i)));

    // R6
    refill_no_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_valid_i && !flush_i && fill_any) |=>
            ($countones(valid_q) == $countones($past(valid_q))));
endmodule

// File: tb/tlb_fa_bench.sv
module tlb_fa_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int VW = 8;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0, lk_v = 1'b0, lk_w = 1'b0, f_v = 1'b0, f_d = 1'b0;
    logic [VW-1:0] lk_vpn = '0, f_vpn = '0;
    logic [PW-1:0] f_ppn = '0;
    logic          hit, dirty;
    logic [PW-1:0] ppn;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model
    bit            m_val [N];
    bit            m_dty [N];
    int            m_vpn [N];
    int            m_ppn [N];
    int            m_rr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_fa #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) u_tlb_fa (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
        .lk_valid_i(lk_v), .lk_vpn_i(lk_vpn), .lk_write_i(lk_w),
        .lk_hit_o(hit), .lk_ppn_o(ppn), .lk_dirty_o(dirty),
        .fill_valid_i(f_v), .fill_vpn_i(f_vpn), .fill_ppn_i(f_ppn), .fill_dirty_i(f_d)
    );

    function automatic int find(int v);
        for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic int first_free();
        for (int i = 0; i < N; i++) if (!m_val[i]) return i;
        return -1;
    endfunction

    task automatic chk(int got, int exp, string req);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cyc(bit fl, bit lv, int lvpn, bit lw, bit fv, int fvpn, int fppn, bit fd,
                       string req);
        int li, fi;
        @(negedge clk);
        flush = fl; lk_v = lv; lk_vpn = VW'(lvpn); lk_w = lw;
        f_v = fv; f_vpn = VW'(fvpn); f_ppn = PW'(fppn); f_d = fd;
        #1;
        li = (lv && !fl) ? find(lvpn) : -1;
        chk(int'(hit), int'(li >= 0), req);
        if (li >= 0) begin
            chk(int'(ppn), m_ppn[li], "R2");
            chk(int'(dirty), int'(m_dty[li]), "R3");
        end
        // model update
        if (fl) begin
            for (int i = 0; i < N; i++) m_val[i] = 0;
        end else begin
            if (li >= 0 && lw) m_dty[li] = 1;
            if (fv) begin
                fi = find(fvpn);
                if (fi < 0) fi = first_free();
                if (fi < 0) begin
                    fi = m_rr;
                    m_rr = (m_rr == N - 1) ? 0 : m_rr + 1;
                end
                m_val[fi] = 1; m_vpn[fi] = fvpn; m_ppn[fi] = fppn; m_dty[fi] = fd;
            end
        end
        @(posedge clk);
    endtask

    task automatic look(int v, string req);
        cyc(0, 1, v, 0, 0, 0, 0, 0, req);
    endtask

    task automatic fill(int v, int p, bit d, string req);
        cyc(0, 0, 0, 0, 1, v, p, d, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        for (int i = 0; i < N; i++) begin m_val[i] = 0; m_dty[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; end
        m_rr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        look(5, "R1");
        look(0, "R1");

        // R4 fill into free slots in order
        for (int i = 0; i < N; i++) fill(10 + i, i + 1, 0, "R4");
        for (int i = 0; i < N; i++) look(10 + i, "R4");
        // R2 no lookup request gives no hit
        cyc(0, 0, 10, 0, 0, 0, 0, 0, "R2");

        // R5 round-robin replacement when full
        fill(30, 33, 0, "R5");
        look(10, "R5");
        look(30, "R5");
        fill(31, 34, 1, "R5");
        look(11, "R5");
        look(31, "R5");

        // R6 refill of stored page rewrites in place, pointer unchanged
        fill(12, 40, 1, "R6");
        look(12, "R6");
        look(13, "R6");
        fill(32, 41, 0, "R6");
        look(12, "R6");
        // R8 one entry per page after duplicate fills
        fill(32, 42, 0, "R8");
        look(32, "R8");

        // R3 write marks dirty, shown the cycle after
        cyc(0, 1, 13, 1, 0, 0, 0, 0, "R3");
        look(13, "R3");

        // R6 fill and mark on the same slot: fill wins
        cyc(0, 1, 14, 1, 1, 14, 9, 0, "R6");
        look(14, "R6");

        // R7 flush: same-cycle lookup misses, fill and write ignored
        cyc(1, 1, 13, 1, 1, 50, 7, 1, "R7");
        look(13, "R7");
        look(50, "R7");
        look(30, "R7");

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            bit fl, lv, lw, fv, fd;
            int lvp, fvp, fpp;
            fl  = ($urandom % 64) == 0;
            lv  = ($urandom % 4) != 0;
            lw  = ($urandom % 3) == 0;
            fv  = ($urandom % 3) == 0;
            fd  = ($urandom % 2) == 1;
            lvp = 20 + int'($urandom % 12);
            fvp = 20 + int'($urandom % 12);
            fpp = int'($urandom % 64);
            cyc(fl, lv, lvp, lw, fv, fvp, fpp, fd, "R2");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule